// File: doc/BRIEF.md
# Write-then-Read Converter Host Controller

This block runs one two-step analog-to-digital converter that works in write-then-read mode, and it drives that converter from a synchronous host clock. A one-cycle start request begins a conversion. The controller lowers chip select and then holds the write strobe low for a minimum time. It then waits before it pulls the read strobe low, takes the byte off the converter bus after an access delay, and hands the byte to the consumer. Every strobe width and every wait is a whole number of clock cycles. Each count is derived from a nanosecond parameter and the clock period, rounded up so that no minimum is ever cut short.

The wait between the rising edge of the write strobe and the falling edge of the read strobe depends on a policy that is sampled with each request. In interrupt policy the controller watches the converter's active-low end-of-conversion line, after it passes through a synchronizer, and reads only once that line has fallen. If the line stays high past a limit, the transaction is abandoned and an error pulse is raised. In fast policy the controller does not use that line and reads after a fixed, shorter delay.

The result leaves on a valid-only stream of one byte per beat. The consumer cannot push back, so it must take each beat in the cycle in which valid is high. The block accepts a new request only when it is idle, so at most one result is ever in flight.

Top module: `adc_conv_host`

## Requirements
- R1: While reset is active and in the idle cycles after it, chip select, write and read (all active low) stay high, and busy, result-valid and timeout-error stay low.
- R2: The write strobe stays low for exactly WR_CYC = ceil(WR_LOW_NS / CLK_PERIOD_NS) consecutive cycles. The default is 120 cycles, which is 600 ns at 5 ns.
- R3: Chip select goes low exactly one cycle before the write strobe falls. It stays low for exactly one cycle after the read strobe rises, or after the error pulse on an abort, and then goes high. Write and read are never low together, and neither is low while chip select is high.
- R4: In fast policy (policy input = 1 when the request is accepted), read falls after exactly FAST_CYC = ceil(FAST_WAIT_NS / CLK_PERIOD_NS) cycles with write high (default 120). The end-of-conversion line is not consulted.
- R5: In interrupt policy (policy input = 0), read is not asserted until the end-of-conversion input (active low) has been seen low. Read falls no more than 4 cycles after that input falls.
- R6: Read stays low for exactly ACC_CYC = ceil(ACCESS_NS / CLK_PERIOD_NS) cycles (default 10). The bus is captured on the last of those cycles. In the cycle when read rises, result-valid is high for exactly one cycle and result-data carries the captured byte.
- R7: In interrupt policy, if the end-of-conversion input is not low after TO_CYC = ceil(TIMEOUT_NS / CLK_PERIOD_NS) cycles with write high (default 400), the transaction ends with no read strobe and no result. Timeout-error is then high for one cycle.
- R8: A start request is accepted only when busy is low. Busy goes high the cycle after an accepted request and falls when chip select is released. Start requests and changes of the policy input while busy have no effect on that transaction: there is exactly one write pulse per accepted request, and the policy stays as it was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled when idle |
| fast_pol_i | input | 1 | Policy select: 1 = fixed-delay read, 0 = wait for end of conversion |
| cvt_int_n_i | input | 1 | Converter end-of-conversion, active low, asynchronous |
| cvt_data_i | input | 8 | Converter data bus |
| cvt_cs_n_o | output | 1 | Converter chip select, active low |
| cvt_wr_n_o | output | 1 | Converter write strobe, active low |
| cvt_rd_n_o | output | 1 | Converter read strobe, active low |
| busy_o | output | 1 | A transaction is in progress |
| res_valid_o | output | 1 | Result beat valid (no ready; one cycle) |
| res_data_o | output | 8 | Result byte |
| timeout_err_o | output | 1 | One-cycle pulse on an interrupt-policy abort |

## Verification
The embedded properties check several rules on every cycle. They cover the exact width of the write strobe and the fast-policy gap from write release to read fall. They also cover how long the abort window lasts, that the strobes never overlap, that each strobe sits inside chip select, and that result-valid lasts a single cycle and never coincides with an error. Other behaviour needs a converter model that reacts to the strobes, so only the bench scenarios show it. This includes reading only after the end-of-conversion line falls, and the latency from that fall to the read. It also includes the captured byte itself, the one-cycle chip-select guard on each side, and the fact that start pulses and policy flips made while busy are ignored.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  typedef enum logic [2:0] {
    HS_IDLE,
    HS_SETUP,
    HS_WRITE,
    HS_WAIT,
    HS_READ,
    HS_HOLD
  } host_state_e;

  // Round a nanosecond interval up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_host_sync.sv
module adc_host_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= RST_VAL;
        else        chain_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= RST_VAL;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/adc_host_timer.sv
module adc_host_timer #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_host_result.sv
module adc_host_result #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic [DW-1:0] bus_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= cap_i;
      if (cap_i) data_o <= bus_i;
    end
  end

  // R6: a result beat lasts a single cycle
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

endmodule

// File: rtl/adc_conv_host.sv
module adc_conv_host
  import adc_host_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter int unsigned WR_LOW_NS     = 600,
  parameter int unsigned FAST_WAIT_NS  = 600,
  parameter int unsigned ACCESS_NS     = 50,
  parameter int unsigned TIMEOUT_NS    = 2000,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned DW            = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          fast_pol_i,
  input  logic          cvt_int_n_i,
  input  logic [DW-1:0] cvt_data_i,
  output logic          cvt_cs_n_o,
  output logic          cvt_wr_n_o,
  output logic          cvt_rd_n_o,
  output logic          busy_o,
  output logic          res_valid_o,
  output logic [DW-1:0] res_data_o,
  output logic          timeout_err_o
);

  localparam int unsigned WR_CYC   = ns_to_cyc(WR_LOW_NS,    CLK_PERIOD_NS);
  localparam int unsigned FAST_CYC = ns_to_cyc(FAST_WAIT_NS, CLK_PERIOD_NS);
  localparam int unsigned ACC_CYC  = ns_to_cyc(ACCESS_NS,    CLK_PERIOD_NS);
  localparam int unsigned TO_CYC   = ns_to_cyc(TIMEOUT_NS,   CLK_PERIOD_NS);
  localparam int unsigned MAX_CYC  = max2(max2(WR_CYC, FAST_CYC), max2(ACC_CYC, TO_CYC));
  localparam int unsigned CW       = $clog2(MAX_CYC + 1);

  host_state_e   st_q, st_d;
  logic          pol_q;
  logic          int_n_s;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;
  logic          cap;
  logic          err_d;

  adc_host_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_int_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cvt_int_n_i),
    .q_o   (int_n_s)
  );

  adc_host_timer #(.W(CW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  adc_host_result #(.DW(DW)) u_result (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_i   (cap),
    .bus_i   (cvt_data_i),
    .valid_o (res_valid_o),
    .data_o  (res_data_o)
  );

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap      = 1'b0;
    err_d    = 1'b0;
    unique case (st_q)
      HS_IDLE:  if (start_i) st_d = HS_SETUP;
      HS_SETUP: begin
        st_d     = HS_WRITE;
        tmr_load = 1'b1;
        tmr_val  = CW'(WR_CYC - 1);
      end
      HS_WRITE: if (tmr_zero) begin
        st_d     = HS_WAIT;
        tmr_load = 1'b1;
        tmr_val  = pol_q ? CW'(FAST_CYC - 1) : CW'(TO_CYC - 1);
      end
      HS_WAIT: begin
        if (!pol_q && !int_n_s) begin
          st_d     = HS_READ;
          tmr_load = 1'b1;
          tmr_val  = CW'(ACC_CYC - 1);
        end else if (tmr_zero) begin
          if (pol_q) begin
            st_d     = HS_READ;
            tmr_load = 1'b1;
            tmr_val  = CW'(ACC_CYC - 1);
          end else begin
            st_d  = HS_HOLD;
            err_d = 1'b1;
          end
        end
      end
      HS_READ: if (tmr_zero) begin
        st_d = HS_HOLD;
        cap  = 1'b1;
      end
      HS_HOLD: st_d = HS_IDLE;
      default: st_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= HS_IDLE;
      pol_q         <= 1'b0;
      cvt_cs_n_o    <= 1'b1;
      cvt_wr_n_o    <= 1'b1;
      cvt_rd_n_o    <= 1'b1;
      busy_o        <= 1'b0;
      timeout_err_o <= 1'b0;
    end else begin
      st_q          <= st_d;
      if (st_q == HS_IDLE && start_i) pol_q <= fast_pol_i;
      cvt_cs_n_o    <= (st_d == HS_IDLE);
      cvt_wr_n_o    <= (st_d != HS_WRITE);
      cvt_rd_n_o    <= (st_d != HS_READ);
      busy_o        <= (st_d != HS_IDLE);
      timeout_err_o <= err_d;
    end
  end

  // Observation counters for the timing properties below.
  localparam logic [CW:0] WR_CMP   = (CW+1)'(WR_CYC);
  localparam logic [CW:0] FAST_CMP = (CW+1)'(FAST_CYC);
  localparam logic [CW:0] TO_CMP   = (CW+1)'(TO_CYC);

  logic [CW:0] wr_low_q;
  logic [CW:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_low_q <= '0;
      gap_q    <= '0;
    end else begin
      if (!cvt_wr_n_o) begin
        if (wr_low_q != '1) wr_low_q <= wr_low_q + 1'b1;
        gap_q <= '0;
      end else begin
        wr_low_q <= '0;
        if (gap_q != '1) gap_q <= gap_q + 1'b1;
      end
    end
  end

  // R2: the write strobe lasts exactly its derived cycle count
  p_wr_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cvt_wr_n_o) |-> (wr_low_q == WR_CMP));

  // R3: write and read never overlap
  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cvt_wr_n_o && !cvt_rd_n_o));

  // R3: strobes only inside chip select
  p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cvt_wr_n_o || !cvt_rd_n_o) |-> !cvt_cs_n_o);

  // R4: fast policy reads a fixed gap after write release
  p_fast_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cvt_rd_n_o) && pol_q) |-> (gap_q == FAST_CMP));

  // R7: abort comes exactly at the end of the timeout window
  p_tmo_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err_o) |-> (gap_q == TO_CMP));

  // R7: an abort never produces a result beat
  p_err_no_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err_o |-> !res_valid_o);

  // R8: chip select is only active while busy
  p_busy_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cvt_cs_n_o |-> busy_o);

endmodule

// File: tb/adc_conv_host_tb.sv
`timescale 1ns/1ps
module adc_conv_host_tb;

  localparam int WR_CYC   = (600 + 4) / 5;   // 120
  localparam int FAST_CYC = (600 + 4) / 5;   // 120
  localparam int ACC_CYC  = (50 + 4) / 5;    // 10
  localparam int TO_CYC   = (2000 + 4) / 5;  // 400
  localparam int CONV_CYC = 160;             // model: 800 ns to end of conversion

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic       fast_pol;
  logic       int_n;
  logic [7:0] bus;
  logic       cs_n, wr_n, rd_n, busy, valid, tmo_err;
  logic [7:0] data;

  always #2.5 clk = ~clk;

  adc_conv_host u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .fast_pol_i    (fast_pol),
    .cvt_int_n_i   (int_n),
    .cvt_data_i    (bus),
    .cvt_cs_n_o    (cs_n),
    .cvt_wr_n_o    (wr_n),
    .cvt_rd_n_o    (rd_n),
    .busy_o        (busy),
    .res_valid_o   (valid),
    .res_data_o    (data),
    .timeout_err_o (tmo_err)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  // Converter model and scoreboard state
  logic [7:0] exp_q[$];
  bit         cur_fast, cur_alive;
  logic [7:0] cur_sample = 8'h00;
  bit         conv_run = 0, conv_done = 0;
  int         conv_cnt = 0;

  assign int_n = !(conv_done || !rd_n);
  assign bus   = rd_n ? 8'hA5 : cur_sample;

  bit p_wr = 1, p_rd = 1, p_cs = 1, p2_cs = 1, p_int = 1, p_valid = 0;
  bit in_gap = 0, exp_cs_rise = 0;
  int wr_low_n = 0, gap_n = 0, rd_low_n = 0;
  int wr_falls = 0, results = 0, errs_seen = 0;

  // Monitor: samples at the falling edge, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n && (!wr_n || !rd_n)) chk(0, "R3 strobe outside chip select", 1, 0);
      if (!wr_n && !rd_n) chk(0, "R3 write and read overlap", 1, 0);
      if (exp_cs_rise) begin
        chk(cs_n == 1'b1, "R3 chip select released after one hold cycle", cs_n, 1);
        chk(busy == 1'b0, "R8 busy clears with chip select", busy, 0);
        exp_cs_rise = 0;
      end
      // write strobe
      if (!wr_n && p_wr) begin
        wr_falls++;
        wr_low_n = 1;
        chk(!p_cs && p2_cs, "R3 one chip-select setup cycle", {p2_cs, p_cs}, 2);
        conv_done = 0;
        conv_run  = 0;
      end else if (!wr_n) begin
        wr_low_n++;
      end
      if (wr_n && !p_wr) begin
        chk(wr_low_n == WR_CYC, "R2 write strobe width", wr_low_n, WR_CYC);
        in_gap = 1;
        gap_n  = 1;
        if (cur_alive) begin conv_run = 1; conv_cnt = 0; end
      end else if (in_gap && rd_n && !tmo_err) begin
        gap_n++;
      end
      // read strobe
      if (!rd_n && p_rd) begin
        in_gap = 0;
        rd_low_n = 1;
        if (cur_fast) begin
          chk(gap_n == FAST_CYC, "R4 fast-policy gap", gap_n, FAST_CYC);
          chk(p_int == 1'b1, "R4 read before end of conversion", p_int, 1);
        end else begin
          chk(p_int == 1'b0, "R5 read only after end of conversion", p_int, 0);
          chk(gap_n >= CONV_CYC && gap_n <= CONV_CYC + 4, "R5 read latency", gap_n, CONV_CYC + 2);
        end
        conv_run  = 0;
        conv_done = 0;
      end else if (!rd_n) begin
        rd_low_n++;
      end
      if (rd_n && !p_rd) begin
        chk(rd_low_n == ACC_CYC, "R6 read strobe width", rd_low_n, ACC_CYC);
        chk(valid == 1'b1, "R6 valid with read release", valid, 1);
        chk(cs_n == 1'b0, "R3 chip select held past read", cs_n, 0);
        exp_cs_rise = 1;
      end
      // abort
      if (tmo_err) begin
        errs_seen++;
        chk(!cur_fast && !cur_alive, "R7 unexpected timeout", 1, 0);
        chk(gap_n == TO_CYC, "R7 timeout window", gap_n, TO_CYC);
        chk(cs_n == 1'b0, "R3 chip select held past abort", cs_n, 0);
        in_gap = 0;
        exp_cs_rise = 1;
      end
      // scoreboard
      if (valid) begin
        results++;
        if (exp_q.size() == 0) chk(0, "R6 unexpected result", data, -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(data == e, "R6 result data", data, e);
        end
      end
      if (p_valid && valid) chk(0, "R6 valid longer than one cycle", 2, 1);
      p_wr = wr_n; p_rd = rd_n; p2_cs = p_cs; p_cs = cs_n; p_int = int_n; p_valid = valid;
      // conversion progress
      if (conv_run) begin
        conv_cnt++;
        if (conv_cnt >= CONV_CYC) begin conv_done = 1; conv_run = 0; end
      end
    end
  end

  task automatic run_one(input bit fast, input bit alive, input logic [7:0] smp, input bit spam);
    int f0, r0, e0, k;
    bit has_res;
    f0 = wr_falls; r0 = results; e0 = errs_seen;
    has_res = fast || alive;
    @(negedge clk);
    cur_fast = fast; cur_alive = alive; cur_sample = smp; fast_pol = fast;
    if (has_res) exp_q.push_back(smp);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after accepted request", busy, 1);
    k = 0;
    while (busy && k < 5000) begin
      @(negedge clk);
      k++;
      if (spam) begin
        start = busy && (k % 9 == 0);
        if (k == 3) fast_pol = !fast;
      end
    end
    start = 1'b0;
    fast_pol = fast;
    repeat (3) @(negedge clk);
    chk(wr_falls == f0 + 1, "R8 one write pulse per request", wr_falls - f0, 1);
    chk(results == r0 + (has_res ? 1 : 0), "R6 result count", results - r0, has_res ? 1 : 0);
    chk(errs_seen == e0 + (has_res ? 0 : 1), "R7 abort count", errs_seen - e0, has_res ? 0 : 1);
    chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
  endtask

  task automatic chk_idle(input string tag);
    chk(cs_n && wr_n && rd_n, {tag, " R1 strobes inactive"}, {cs_n, wr_n, rd_n}, 7);
    chk(!busy && !valid && !tmo_err, {tag, " R1 status low"}, {busy, valid, tmo_err}, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; fast_pol = 1'b0;
    cur_fast = 0; cur_alive = 1;
    repeat (4) @(negedge clk);
    chk_idle("in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle("after reset");

    run_one(1'b1, 1'b1, 8'h3C, 1'b0);  // R4 fast policy
    run_one(1'b0, 1'b1, 8'h00, 1'b0);  // R5 interrupt policy
    run_one(1'b0, 1'b1, 8'hFF, 1'b1);  // R8 start and policy flips ignored
    run_one(1'b1, 1'b1, 8'hC3, 1'b1);  // R8 with fast policy
    run_one(1'b0, 1'b0, 8'h77, 1'b0);  // R7 dead converter, timeout
    run_one(1'b1, 1'b0, 8'h5A, 1'b0);  // R4 fast policy ignores missing interrupt
    run_one(1'b0, 1'b1, 8'h96, 1'b0);  // R5 recovery after abort
    chk_idle("end");

    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

endmodule